// File: doc/BRIEF.md
# Transmit Descriptor Status Write-Back

This block closes a transmit descriptor when a packet has left the transmit path. Between the acceptance of a packet's first descriptor and the end of the packet it gathers status events into sticky flags. Events include underflow, collisions, carrier problems, checksum-offload failures, flushes, memory errors and timestamp capture. It also counts collisions. When the packet ends, it builds the 32-bit status word for the packet's last descriptor. That word hands ownership back to software and carries a summary error bit.

The block also checks the last descriptor's control word. A control word that is all ones, or that has the context, first and last flags set together, is closed with only the descriptor-error and last flags set. The finished word is offered on a simple memory-write port. The request is held until an acknowledge arrives. If the packet's first descriptor asked for an interrupt on completion, a one-cycle interrupt follows the acknowledge.

Top module: `txdesc_close`

## Requirements
- R1: After reset, wbReq and txIrq are 0 and wbData is all zeros.
- R2: A pktDone sampled while no write-back is pending raises wbReq on the next cycle. wbReq stays high until wbAck is sampled high and is low on the cycle after that.
- R3: In a normal close, bits 31 (owner) and 30 (context) are 0 and bit 28 (last) is 1. Bit 29 copies bit 29 of descCtrl. Bit 23 (descriptor error) and the reserved bits 27:24 and 22:18 are 0.
- R4: Each evtIn bit is reported at its own word bit: 0 IP header error→0, 1 deferred→1, 2 underflow→2, 3 excessive deferral→3, 4 excessive collisions→8, 5 late collision→9, 6 no carrier→10, 7 loss of carrier→11, 8 payload checksum error→12, 9 software flush→13, 10 jabber→14, 12 uncorrectable packet-memory error→16.
- R5: Events seen from the pktStart cycle through the pktDone cycle are all reported. A pktStart discards the events of earlier cycles.
- R6: Bit 15 is 1 exactly when any of word bits 0, 2, 3, 8 to 14 or 16 is 1.
- R7: Bit 17 is 1 only when evtIn bit 13 (timestamp captured) was seen for the packet and tsEnable is high at pktDone.
- R8: Bits 7:4 hold the number of collInc pulses since pktStart, saturating at 15. A pktStart clears the count.
- R9: A descCtrl that is all ones, or that has bits 30, 29 and 28 all set, gives the word 0x1080_0000, whatever the events.
- R10: txIrq pulses for exactly one cycle, on the cycle after the acknowledge, when firstIoc was high with the packet's pktStart. This holds for descriptor-error closes too. Otherwise txIrq stays low.
- R11: wbData does not change while wbReq is high. A pktDone that arrives while wbReq is high is ignored.
- R12: evtIn bit 11 (uncorrectable transmit FIFO error) sets bit 13 and leaves bit 16 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | First descriptor of a new packet accepted |
| firstIoc | input | 1 | Interrupt-on-completion flag of the first descriptor, valid with pktStart |
| pktDone | input | 1 | Packet finished; close its last descriptor |
| descCtrl | input | 32 | Control word of the last descriptor, valid with pktDone |
| evtIn | input | 14 | Status event pulses (bit meanings in R4, R7, R12) |
| collInc | input | 1 | One collision occurred |
| tsEnable | input | 1 | Timestamping enabled |
| wbAck | input | 1 | Write-back accepted |
| wbReq | output | 1 | Write-back request, held until acknowledged |
| wbData | output | 32 | Status word to write back |
| txIrq | output | 1 | One-cycle transmit-complete interrupt |

## Verification
The bench aims at events that arrive in the same cycle as pktStart or pktDone. A design that cleared too late or sampled too early would drop them or carry stale flags into the next packet. It drives the collision counter well past 15, where a design without saturation would wrap to a small count. It tries descCtrl values that are one flag short of malformed, which catch a validity check that tests too few bits. It sends a second pktDone and new events during a pending write-back; a design without that guard would corrupt the word or issue a spurious second request.

// File: rtl/txdesc_close_pkg.sv
package txdesc_close_pkg;
  localparam int WORD_W = 32;
  localparam int COLL_W = 4;
  localparam int EVT_W  = 14;

  // event vector bit meanings
  localparam int EV_TSTAMP = 13;

  // status word bit positions
  localparam int ST_CTX     = 30;
  localparam int ST_FIRST   = 29;
  localparam int ST_LAST    = 28;
  localparam int ST_DESCERR = 23;
  localparam int ST_TS      = 17;
  localparam int ST_SUMMARY = 15;
  localparam int ST_COLL_LO = 4;

  // word bit reached by each event, indexed by event number
  localparam int EV_POS [EVT_W] = '{0, 1, 2, 3, 8, 9, 10, 11, 12, 13, 14, 13, 16, 17};

  // bits feeding the summary error flag
  localparam logic [WORD_W-1:0] SUMMARY_MASK = 32'h0001_7F0D;

  typedef enum logic [0:0] {CS_IDLE, CS_WB} closeState_e;

  typedef struct packed {
    logic capture;
  } closeCtl_t;

  function automatic logic isMalformed(input logic [WORD_W-1:0] c);
    return (&c) || (c[ST_CTX] && c[ST_FIRST] && c[ST_LAST]);
  endfunction
endpackage

// File: rtl/txdesc_close_ctrl.sv
module txdesc_close_ctrl
  import txdesc_close_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      pktDone,
  input  logic      wbAck,
  input  logic      irqArmed,
  output closeCtl_t ctl,
  output logic      wbReq,
  output logic      txIrq
);
  closeState_e state;

  always_comb begin
    ctl.capture = (state == CS_IDLE) && pktDone;
    wbReq       = (state == CS_WB);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= CS_IDLE;
      txIrq <= 1'b0;
    end else begin
      txIrq <= (state == CS_WB) && wbAck && irqArmed;
      case (state)
        CS_IDLE: if (pktDone) state <= CS_WB;
        CS_WB:   if (wbAck)   state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end

  // R2: request held until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && !wbAck |=> wbReq);

  // R10: interrupt lasts one cycle
  a_r10_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);

  // R10: interrupt only right after an accepted write-back
  a_r10_irq_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(wbReq && wbAck));
endmodule

// File: rtl/txdesc_close_dp.sv
module txdesc_close_dp
  import txdesc_close_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  closeCtl_t         ctl,
  input  logic              pktStart,
  input  logic              firstIoc,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              collInc,
  input  logic              tsEnable,
  input  logic [WORD_W-1:0] descCtrl,
  output logic [WORD_W-1:0] wbWord,
  output logic              irqArmed
);
  logic [EVT_W-1:0]  sticky, nextEvt;
  logic [COLL_W-1:0] collCnt, baseColl, nextColl;
  logic              iocLatch, nextIoc;
  logic [WORD_W-1:0] raw, assembled;

  always_comb begin
    nextEvt  = (pktStart ? '0 : sticky) | evtIn;
    baseColl = pktStart ? '0 : collCnt;
    nextColl = (collInc && (baseColl != '1)) ? baseColl + 1'b1 : baseColl;
    nextIoc  = pktStart ? firstIoc : iocLatch;
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < EVT_W; i++) begin
      raw[EV_POS[i]] = raw[EV_POS[i]] | nextEvt[i];
    end
    raw[ST_TS]                   = nextEvt[EV_TSTAMP] & tsEnable;
    raw[ST_COLL_LO +: COLL_W]    = nextColl;
    raw[ST_SUMMARY]              = |(raw & SUMMARY_MASK);
    raw[ST_LAST]                 = 1'b1;
    raw[ST_FIRST]                = descCtrl[ST_FIRST];
    assembled = raw;
    if (isMalformed(descCtrl)) begin
      assembled              = '0;
      assembled[ST_DESCERR]  = 1'b1;
      assembled[ST_LAST]     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sticky   <= '0;
      collCnt  <= '0;
      iocLatch <= 1'b0;
      wbWord   <= '0;
      irqArmed <= 1'b0;
    end else begin
      sticky   <= nextEvt;
      collCnt  <= nextColl;
      iocLatch <= nextIoc;
      if (ctl.capture) begin
        wbWord   <= assembled;
        irqArmed <= nextIoc;
      end
    end
  end

  // R8: collision count saturates
  a_r8_coll_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (collCnt == '1) && collInc && !pktStart |=> (collCnt == '1));

  // R9: all-ones control word closes with error and last flags
  a_r9_malformed_close: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture && (&descCtrl) |=> wbWord[ST_DESCERR] && wbWord[ST_LAST]);
endmodule

// File: rtl/txdesc_close.sv
module txdesc_close
  import txdesc_close_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktStart,
  input  logic              firstIoc,
  input  logic              pktDone,
  input  logic [WORD_W-1:0] descCtrl,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              collInc,
  input  logic              tsEnable,
  input  logic              wbAck,
  output logic              wbReq,
  output logic [WORD_W-1:0] wbData,
  output logic              txIrq
);
  closeCtl_t ctl;
  logic      irqArmed;

  txdesc_close_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pktDone(pktDone), .wbAck(wbAck),
    .irqArmed(irqArmed), .ctl(ctl), .wbReq(wbReq), .txIrq(txIrq)
  );

  txdesc_close_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pktStart(pktStart), .firstIoc(firstIoc),
    .evtIn(evtIn), .collInc(collInc), .tsEnable(tsEnable), .descCtrl(descCtrl),
    .wbWord(wbData), .irqArmed(irqArmed)
  );

  // R11: word frozen while the request is pending
  a_r11_word_stable: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && $past(wbReq) |-> $stable(wbData));
endmodule

// File: tb/txdesc_close_tb.sv
module txdesc_close_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktStart = 1'b0, firstIoc = 1'b0, pktDone = 1'b0;
  logic [31:0] descCtrl = '0;
  logic [13:0] evtIn = '0;
  logic        collInc = 1'b0, tsEnable = 1'b0, wbAck = 1'b0;
  logic        wbReq, txIrq;
  logic [31:0] wbData;
  int          tests = 0, fails = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  txdesc_close dut_i (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .firstIoc(firstIoc),
    .pktDone(pktDone), .descCtrl(descCtrl), .evtIn(evtIn), .collInc(collInc),
    .tsEnable(tsEnable), .wbAck(wbAck), .wbReq(wbReq), .wbData(wbData), .txIrq(txIrq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [13:0] e, input int coll,
                                        input logic tsEn, input logic [31:0] c);
    logic [31:0] w;
    if ((&c) || (c[30] && c[29] && c[28])) return 32'h1080_0000;
    w = '0;
    w[0] = e[0]; w[1] = e[1]; w[2] = e[2]; w[3] = e[3];
    w[8] = e[4]; w[9] = e[5]; w[10] = e[6]; w[11] = e[7];
    w[12] = e[8]; w[13] = e[9] | e[11]; w[14] = e[10]; w[16] = e[12];
    w[17] = e[13] & tsEn;
    w[7:4] = (coll > 15) ? 4'd15 : coll[3:0];
    w[15] = w[0] | w[2] | w[3] | (|w[14:8]) | w[16];
    w[28] = 1'b1;
    w[29] = c[29];
    return w;
  endfunction

  task automatic drive(input logic st, input logic ioc, input logic [13:0] ev, input logic cinc);
    pktStart = st; firstIoc = ioc; evtIn = ev; collInc = cinc;
    @(negedge clk);
    pktStart = 0; firstIoc = 0; evtIn = '0; collInc = 0;
  endtask

  task automatic closePkt(input logic [31:0] ctrl, input logic [13:0] ev, input logic cinc,
                          input logic [31:0] expW, input logic expIrq, input string req);
    pktDone = 1; descCtrl = ctrl; evtIn = ev; collInc = cinc;
    @(negedge clk);
    pktDone = 0; descCtrl = '0; evtIn = '0; collInc = 0;
    chk({req, " R2 request raised"}, {31'b0, wbReq}, 32'd1);
    chk({req, " word"}, wbData, expW);
    @(negedge clk);
    chk({req, " R2 request held"}, {31'b0, wbReq}, 32'd1);
    chk({req, " R11 word stable"}, wbData, expW);
    wbAck = 1;
    @(negedge clk);
    wbAck = 0;
    chk({req, " R2 request dropped"}, {31'b0, wbReq}, 32'd0);
    chk({req, " R10 interrupt"}, {31'b0, txIrq}, {31'b0, expIrq});
    @(negedge clk);
    chk({req, " R10 one-cycle interrupt"}, {31'b0, txIrq}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 wbReq", {31'b0, wbReq}, 32'd0);
    chk("R1 txIrq", {31'b0, txIrq}, 32'd0);
    chk("R1 wbData", wbData, 32'd0);
  endtask

  task automatic t_clean;
    drive(1, 1, '0, 0);
    closePkt(32'h3000_0000, '0, 0, model('0, 0, 0, 32'h3000_0000), 1, "R3 R10 clean close");
    drive(1, 0, '0, 0);
    closePkt(32'h1000_0000, '0, 0, 32'h1000_0000, 0, "R3 middle-flag close");
  endtask

  task automatic t_events;
    tsEnable = 1;
    for (int i = 0; i < 13; i++) begin
      logic [13:0] ev;
      ev = 14'd1 << i;
      drive(1, 0, ev, 0);
      closePkt(32'h1000_0000, '0, 0, model(ev, 0, 1, 32'h1000_0000), 0, $sformatf("R4 R6 event %0d", i));
    end
  endtask

  task automatic t_fifo_ecc;
    drive(1, 0, 14'h0800, 0);
    closePkt(32'h1000_0000, '0, 0, model(14'h0800, 0, 1, 32'h1000_0000), 0, "R12 fifo error");
    chk("R12 flush bit", {31'b0, wbData[13]}, 32'd1);
    chk("R12 memory bit clear", {31'b0, wbData[16]}, 32'd0);
  endtask

  task automatic t_sticky;
    drive(1, 0, 14'h0004, 0);
    drive(0, 0, 14'h0002, 0);
    closePkt(32'h1000_0000, 14'h0001, 0, model(14'h0007, 0, 1, 32'h1000_0000), 0, "R5 accumulate");
    drive(0, 0, 14'h0020, 0);
    drive(1, 1, 14'h0400, 0);
    closePkt(32'h1000_0000, 14'h0040, 0, model(14'h0440, 0, 1, 32'h1000_0000), 1, "R5 cleared at start");
  endtask

  task automatic t_tstamp;
    tsEnable = 0;
    drive(1, 0, 14'h2000, 0);
    closePkt(32'h1000_0000, '0, 0, 32'h1000_0000, 0, "R7 timestamp disabled");
    tsEnable = 1;
    drive(1, 0, 14'h2000, 0);
    closePkt(32'h1000_0000, '0, 0, 32'h1002_0000, 0, "R7 timestamp enabled");
    drive(1, 0, '0, 0);
    closePkt(32'h1000_0000, '0, 0, 32'h1000_0000, 0, "R7 no capture");
  endtask

  task automatic t_coll;
    drive(1, 0, '0, 1);
    drive(0, 0, '0, 1);
    closePkt(32'h1000_0000, '0, 1, model('0, 3, 1, 32'h1000_0000), 0, "R8 three collisions");
    drive(1, 0, '0, 1);
    for (int i = 0; i < 19; i++) drive(0, 0, '0, 1);
    closePkt(32'h1000_0000, '0, 0, model('0, 20, 1, 32'h1000_0000), 0, "R8 saturate");
    drive(1, 0, '0, 0);
    closePkt(32'h1000_0000, '0, 0, 32'h1000_0000, 0, "R8 cleared");
  endtask

  task automatic t_malformed;
    drive(1, 1, 14'h3FFF, 1);
    closePkt(32'hFFFF_FFFF, 14'h0004, 0, 32'h1080_0000, 1, "R9 all ones");
    drive(1, 0, 14'h0004, 0);
    closePkt(32'h7000_0000, '0, 0, 32'h1080_0000, 0, "R9 ctx first last");
    drive(1, 0, '0, 0);
    closePkt(32'h6000_0000, '0, 0, model('0, 0, 1, 32'h6000_0000), 0, "R9 ctx first only");
    drive(1, 0, '0, 0);
    closePkt(32'hFFFF_FFFE, '0, 0, model('0, 0, 1, 32'hFFFF_FFFE), 0, "R9 not quite all ones");
  endtask

  task automatic t_busy;
    logic [31:0] exp;
    exp = model(14'h0004, 0, 1, 32'h1000_0000);
    drive(1, 0, 14'h0004, 0);
    pktDone = 1; descCtrl = 32'h1000_0000;
    @(negedge clk);
    pktDone = 0; descCtrl = '0;
    chk("R11 first word", wbData, exp);
    pktDone = 1; descCtrl = 32'hFFFF_FFFF; evtIn = 14'h3FFF;
    @(negedge clk);
    pktDone = 0; descCtrl = '0; evtIn = '0;
    chk("R11 word kept", wbData, exp);
    chk("R11 request kept", {31'b0, wbReq}, 32'd1);
    wbAck = 1;
    @(negedge clk);
    wbAck = 0;
    chk("R11 released", {31'b0, wbReq}, 32'd0);
    @(negedge clk);
    chk("R11 late pktDone ignored", {31'b0, wbReq}, 32'd0);
    chk("R11 word unchanged", wbData, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_events();
    t_fifo_ecc();
    t_sticky();
    t_tstamp();
    t_coll();
    t_malformed();
    t_busy();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule